// File: doc/BRIEF.md
# Ethernet Controller Interrupt Status Block

This block collects the interrupt events of a small Ethernet controller and keeps them as status bits. Event pulses come from the receive path, the transmit-page allocator, the link monitor, the statistics counters and the transmitter. Each status bit clears by its own rule. Some clear through a write-one acknowledge. One clears when the allocator handles its next transaction. The merged protocol-handler bit clears through side effects of writes to the control register and of counter reads. A per-bit mask selects which status bits drive the single registered interrupt request line.

Software reaches the block through a single-cycle register port. The write strobe takes an address and a data byte. The read port returns data combinationally for the address presented. Writes to the status address act as an acknowledge. A separate strobe tells the block that software has read the statistics counter. After a fatal transmit error, a small transmit-enable state machine drops the transmitter enable and latches the reason. The state machine has two states. `TXS_HALT` is the reset state and is also entered after a fatal error or after a control write with the enable bit at 0. `TXS_RUN` is entered from `TXS_HALT` when software writes the control register with the enable bit at 1 and no fatal error arrives in the same cycle.

Register addresses:
- 0: status on read, acknowledge on write.
- 1: mask, bits 2:0.
- 2: control. Bit 0 is link-change enable, bit 1 is counter-rollover enable, bit 2 is transmit-error enable and bit 3 is transmit enable.
- 3: information, read only. Bits 1:0 hold the fatal reason, bit 2 holds transmit success and bit 3 holds the allocation-failed flag.

Status bits: bit 0 is receive overrun, bit 1 is allocation done and bit 2 is the merged protocol-handler bit.

Top module: `eth_irq_top`

## Requirements
- R1: After reset the status, mask and control registers read 0, the interrupt request is low and the transmit enable is low.
- R2: A pulse on any bit of `rx_abort` (buffer allocation failed, frame over 2K bytes, discard mode) sets status bit 0. The bit stays set until a write to address 0 with data bit 0 at 1. An acknowledge write with data bit 0 at 0 leaves it set.
- R3: A successful allocation response sets status bit 1. An allocation request, or a failed allocation response, clears it. Information bit 3 always reads as the inverse of status bit 1.
- R4: With control bit 0 at 1, a link-change pulse latches a link condition that sets status bit 2. The condition clears only on a control write with bit 0 at 0. With control bit 0 at 0, the link pulse has no effect.
- R5: With control bit 1 at 1, a counter-rollover pulse latches a condition that sets status bit 2. The condition clears only on a `ctr_rd` pulse.
- R6: A fatal transmit pulse drives `tx_enable` low and latches `fatal_why` into information bits 1:0 (0 SQE error, 1 lost carrier, 2 late collision, 3 sixteen collisions). It also drives information bit 2 (transmit success) low. If control bit 2 is 1, it latches a transmit-error condition that sets status bit 2.
- R7: A control write with bit 3 at 1 clears the transmit-error condition, raises `tx_enable` and raises information bit 2.
- R8: Acknowledge writes do not change status bits 1 or 2. Status bits 7:3 always read 0.
- R9: When a set event and a clear action reach the same condition in the same cycle, the condition ends up set.
- R10: `irq` equals the OR of status bits 2:0 ANDed with mask bits 2:0, registered, so it changes one clock after the status changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data for rd_addr |
| ctr_rd | input | 1 | Statistics counter read strobe |
| rx_abort | input | 3 | Receive abort pulses, one per reason |
| alloc_req | input | 1 | Allocation request accepted |
| alloc_rsp_valid | input | 1 | Allocation response valid |
| alloc_rsp_fail | input | 1 | Allocation response is a failure |
| ev_link | input | 1 | Link-test state change pulse |
| ev_roll | input | 1 | Statistics counter rollover pulse |
| ev_tx_fatal | input | 1 | Fatal transmit error pulse |
| fatal_why | input | 2 | Reason code with ev_tx_fatal |
| irq | output | 1 | Interrupt request |
| tx_enable | output | 1 | Transmitter enable |
| fatal_reason | output | 2 | Latched fatal reason |

## Verification
The checker module checks four behaviours on every clock:
- the receive-overrun bit holding without a matching acknowledge;
- allocator responses setting and clearing the allocation bit;
- a fatal error dropping the transmit enable on the next cycle;
- the reserved status bits reading 0 and the one-cycle lag of the request line behind masked status.

The bench scenarios cover the behaviours that depend on a chosen ordering of writes. These include the link condition surviving writes that keep its enable set, and the rollover condition ignoring a disabled enable. They also include each fatal reason code, and the set-beats-clear collisions. A sweep of all eight mask values against all eight status patterns checks the request line.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
    localparam int DW    = 8;
    localparam int AW    = 2;
    localparam int NSTAT = 3;
    localparam int NPH   = 3;

    localparam logic [AW-1:0] A_STAT = 2'd0;
    localparam logic [AW-1:0] A_MASK = 2'd1;
    localparam logic [AW-1:0] A_CTRL = 2'd2;
    localparam logic [AW-1:0] A_INFO = 2'd3;

    localparam int B_RXOVR = 0;
    localparam int B_ALLOC = 1;
    localparam int B_PH    = 2;

    localparam int C_LINK  = 0;
    localparam int C_ROLL  = 1;
    localparam int C_TXERR = 2;
    localparam int C_TXEN  = 3;

    typedef enum logic [1:0] {
        WHY_SQE     = 2'd0,
        WHY_NOCARR  = 2'd1,
        WHY_LATECOL = 2'd2,
        WHY_COL16   = 2'd3
    } fatal_why_t;

    typedef enum logic {
        TXS_HALT = 1'b0,
        TXS_RUN  = 1'b1
    } txs_t;
endpackage

// File: rtl/eth_irq_sticky.sv
module eth_irq_sticky #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[i] <= 1'b0;
            else
                q_o[i] <= set_i[i] | (q_o[i] & ~clr_i[i]);
        end
    end
endmodule

// File: rtl/eth_irq_txctl.sv
module eth_irq_txctl
    import eth_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       ctl_txen,
    input  logic       fatal_ev,
    input  logic [1:0] fatal_code,
    output logic       tx_en_o,
    output logic       tx_ok_o,
    output logic [1:0] why_o,
    output logic       rearm_o
);
    txs_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TXS_HALT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TXS_HALT: if (ctl_wr && ctl_txen && !fatal_ev) st_d = TXS_RUN;
            TXS_RUN:  if (fatal_ev || (ctl_wr && !ctl_txen)) st_d = TXS_HALT;
            default:  st_d = TXS_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            why_o   <= WHY_SQE;
            tx_ok_o <= 1'b1;
        end else if (fatal_ev) begin
            why_o   <= fatal_code;
            tx_ok_o <= 1'b0;
        end else if (ctl_wr && ctl_txen) begin
            tx_ok_o <= 1'b1;
        end
    end

    assign tx_en_o = (st_q == TXS_RUN);
    assign rearm_o = ctl_wr && ctl_txen;
endmodule

// File: rtl/eth_irq_top.sv
module eth_irq_top
    import eth_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       ctr_rd,
    input  logic [2:0] rx_abort,
    input  logic       alloc_req,
    input  logic       alloc_rsp_valid,
    input  logic       alloc_rsp_fail,
    input  logic       ev_link,
    input  logic       ev_roll,
    input  logic       ev_tx_fatal,
    input  logic [1:0] fatal_why,
    output logic       irq,
    output logic       tx_enable,
    output logic [1:0] fatal_reason
);
    logic             ack_wr, mask_wr, ctl_wr, rearm, tx_ok;
    logic [NSTAT-1:0] mask_q;
    logic [NPH-1:0]   en_q, ph_set, ph_clr, ph_pend;
    logic [1:0]       lat_set, lat_clr, lat_q;
    logic [DW-1:0]    stat_w, info_w;
    logic             irq_q;

    assign ack_wr  = wr_en && (wr_addr == A_STAT);
    assign mask_wr = wr_en && (wr_addr == A_MASK);
    assign ctl_wr  = wr_en && (wr_addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            en_q   <= '0;
        end else begin
            if (mask_wr) mask_q <= wr_data[NSTAT-1:0];
            if (ctl_wr)  en_q   <= wr_data[NPH-1:0];
        end
    end

    eth_irq_txctl u_txctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_txen   (wr_data[C_TXEN]),
        .fatal_ev   (ev_tx_fatal),
        .fatal_code (fatal_why),
        .tx_en_o    (tx_enable),
        .tx_ok_o    (tx_ok),
        .why_o      (fatal_reason),
        .rearm_o    (rearm)
    );

    assign ph_set[C_LINK]  = ev_link     && en_q[C_LINK];
    assign ph_set[C_ROLL]  = ev_roll     && en_q[C_ROLL];
    assign ph_set[C_TXERR] = ev_tx_fatal && en_q[C_TXERR];
    assign ph_clr[C_LINK]  = ctl_wr && !wr_data[C_LINK];
    assign ph_clr[C_ROLL]  = ctr_rd;
    assign ph_clr[C_TXERR] = rearm;

    eth_irq_sticky #(.N(NPH)) u_ph (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ph_set),
        .clr_i (ph_clr),
        .q_o   (ph_pend)
    );

    assign lat_set[0] = |rx_abort;
    assign lat_clr[0] = ack_wr && wr_data[B_RXOVR];
    assign lat_set[1] = alloc_rsp_valid && !alloc_rsp_fail;
    assign lat_clr[1] = alloc_req || (alloc_rsp_valid && alloc_rsp_fail);

    eth_irq_sticky #(.N(2)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (lat_set),
        .clr_i (lat_clr),
        .q_o   (lat_q)
    );

    always_comb begin
        stat_w          = '0;
        stat_w[B_RXOVR] = lat_q[0];
        stat_w[B_ALLOC] = lat_q[1];
        stat_w[B_PH]    = |ph_pend;
        info_w          = {4'b0, ~lat_q[1], tx_ok, fatal_reason};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(stat_w[NSTAT-1:0] & mask_q);
    end
    assign irq = irq_q;

    always_comb begin
        unique case (rd_addr)
            A_STAT:  rd_data = stat_w;
            A_MASK:  rd_data = {{(DW-NSTAT){1'b0}}, mask_q};
            A_CTRL:  rd_data = {4'b0, tx_enable, en_q};
            default: rd_data = info_w;
        endcase
    end
endmodule

// File: rtl/eth_irq_checker.sv
module eth_irq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       alloc_rsp_valid,
    input logic       alloc_rsp_fail,
    input logic       ev_tx_fatal,
    input logic [7:0] status,
    input logic [2:0] mask,
    input logic       irq,
    input logic       tx_enable
);
    a_r2_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !(wr_en && wr_addr == 2'd0 && wr_data[0])) |=> status[0]);

    a_r3_alloc_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_rsp_valid && !alloc_rsp_fail) |=> status[1]);

    a_r3_alloc_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_rsp_valid && alloc_rsp_fail) |=> !status[1]);

    a_r6_fatal_halt: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_fatal |=> !tx_enable);

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:3] == 5'd0);

    a_r10_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(status[2:0] & mask))));
endmodule

bind eth_irq_top eth_irq_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_addr         (wr_addr),
    .wr_data         (wr_data),
    .alloc_rsp_valid (alloc_rsp_valid),
    .alloc_rsp_fail  (alloc_rsp_fail),
    .ev_tx_fatal     (ev_tx_fatal),
    .status          (stat_w),
    .mask            (mask_q),
    .irq             (irq),
    .tx_enable       (tx_enable)
);

// File: tb/tb_eth_irq_top.sv
`timescale 1ns/1ps
module tb_eth_irq_top;
    logic       clk = 0, rst_n = 0;
    logic       wr_en = 0;
    logic [1:0] wr_addr = 0, rd_addr = 0, fatal_why = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic       ctr_rd = 0, alloc_req = 0, alloc_rsp_valid = 0, alloc_rsp_fail = 0;
    logic [2:0] rx_abort = 0;
    logic       ev_link = 0, ev_roll = 0, ev_tx_fatal = 0;
    logic       irq, tx_enable;
    logic [1:0] fatal_reason;
    int         n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    eth_irq_top dut (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rd(input logic [1:0] a);
        rd_addr = a;
        return 8'h00;
    endfunction

    task automatic rdchk(input string req, input logic [1:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic idle();
        wr_en = 0; ctr_rd = 0; rx_abort = 0; alloc_req = 0; alloc_rsp_valid = 0;
        alloc_rsp_fail = 0; ev_link = 0; ev_roll = 0; ev_tx_fatal = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
    endtask

    task automatic alloc(input logic ok);
        @(negedge clk);
        alloc_rsp_valid = 1; alloc_rsp_fail = !ok;
        step();
    endtask

    task automatic areq();
        @(negedge clk); alloc_req = 1; step();
    endtask

    task automatic rxab(input logic [2:0] v);
        @(negedge clk); rx_abort = v; step();
    endtask

    task automatic roll();
        @(negedge clk); ev_roll = 1; step();
    endtask

    task automatic crd();
        @(negedge clk); ctr_rd = 1; step();
    endtask

    task automatic fatal(input logic [1:0] w);
        @(negedge clk); ev_tx_fatal = 1; fatal_why = w; step();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rdchk("R1 status", 2'd0, 8'h00);
        rdchk("R1 mask", 2'd1, 8'h00);
        rdchk("R1 ctrl", 2'd2, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 tx_enable", {7'd0, tx_enable}, 8'h00);

        // R2 each abort reason latches, zero ack ignored, one ack clears
        for (int r = 0; r < 3; r++) begin
            rxab(3'(1 << r));
            rdchk("R2 set", 2'd0, 8'h01);
            wr(2'd0, 8'h00);
            rdchk("R2 zero ack", 2'd0, 8'h01);
            step();
            rdchk("R2 hold", 2'd0, 8'h01);
            wr(2'd0, 8'h01);
            rdchk("R2 ack clears", 2'd0, 8'h00);
        end

        // R3 allocation done and inverse failed flag
        alloc(1);
        rdchk("R3 success", 2'd0, 8'h02);
        rdchk("R3 failed flag low", 2'd3, 8'h04);
        areq();
        rdchk("R3 request clears", 2'd0, 8'h00);
        rdchk("R3 failed flag high", 2'd3, 8'h0C);
        alloc(1);
        alloc(0);
        rdchk("R3 fail clears", 2'd0, 8'h00);

        // R8 acknowledge leaves other bits alone
        alloc(1);
        rxab(3'b100);
        wr(2'd0, 8'hFE);
        rdchk("R8 ack no effect", 2'd0, 8'h03);
        wr(2'd0, 8'hFF);
        rdchk("R8 only rx cleared", 2'd0, 8'h02);
        areq();

        // R4 link condition
        @(negedge clk); ev_link = 1; step();
        rdchk("R4 disabled ignored", 2'd0, 8'h00);
        wr(2'd2, 8'h01);
        @(negedge clk); ev_link = 1; step();
        rdchk("R4 set", 2'd0, 8'h04);
        crd();
        wr(2'd2, 8'h03);
        rdchk("R4 kept while enabled", 2'd0, 8'h04);
        wr(2'd2, 8'h00);
        rdchk("R4 cleared by enable low", 2'd0, 8'h00);

        // R5 rollover condition
        wr(2'd2, 8'h02);
        roll();
        rdchk("R5 set", 2'd0, 8'h04);
        wr(2'd2, 8'h00);
        rdchk("R5 enable low keeps", 2'd0, 8'h04);
        crd();
        rdchk("R5 counter read clears", 2'd0, 8'h00);

        // R6 / R7 each reason code
        for (int w = 0; w < 4; w++) begin
            wr(2'd2, 8'h0C);
            check("R7 tx_enable high", {7'd0, tx_enable}, 8'h01);
            rdchk("R7 info ok", 2'd3, 8'h0C | 8'(fatal_reason));
            fatal(2'(w));
            check("R6 tx_enable low", {7'd0, tx_enable}, 8'h00);
            check("R6 reason port", {6'd0, fatal_reason}, 8'(w));
            rdchk("R6 info", 2'd3, 8'h08 | 8'(w));
            rdchk("R6 status", 2'd0, 8'h04);
            wr(2'd2, 8'h0C);
            rdchk("R7 rearm clears", 2'd0, 8'h00);
            check("R7 running", {7'd0, tx_enable}, 8'h01);
        end
        wr(2'd2, 8'h08);
        fatal(2'd1);
        rdchk("R6 disabled no status", 2'd0, 8'h00);
        check("R6 halt without enable", {7'd0, tx_enable}, 8'h00);

        // R9 set wins over clear
        @(negedge clk); rx_abort = 3'b001; wr_en = 1; wr_addr = 0; wr_data = 8'h01; step();
        rdchk("R9 rx set wins", 2'd0, 8'h01);
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h01);
        @(negedge clk); ev_link = 1; wr_en = 1; wr_addr = 2; wr_data = 8'h00; step();
        rdchk("R9 link set wins", 2'd0, 8'h04);
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h02);
        @(negedge clk); ev_roll = 1; ctr_rd = 1; step();
        rdchk("R9 roll set wins", 2'd0, 8'h04);
        crd();
        @(negedge clk); alloc_req = 1; alloc_rsp_valid = 1; alloc_rsp_fail = 0; step();
        rdchk("R9 alloc set wins", 2'd0, 8'h02);
        areq();

        // R10 registered timing
        wr(2'd1, 8'h01);
        rxab(3'b010);
        check("R10 not yet", {7'd0, irq}, 8'h00);
        step();
        check("R10 one later", {7'd0, irq}, 8'h01);
        wr(2'd0, 8'h01);

        // R10 sweep of mask against status pattern (ctrl has rollover enabled)
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 8; p++) begin
                wr(2'd0, 8'h01); areq(); crd();
                wr(2'd1, 8'(m));
                if (p[0]) rxab(3'b001);
                if (p[1]) alloc(1);
                if (p[2]) roll();
                step();
                rdchk("R10 pattern", 2'd0, 8'(p));
                check("R10 sweep", {7'd0, irq}, {7'd0, |(p[2:0] & m[2:0])});
            end
        end

        summary();
        $finish;
    end
endmodule